// File: doc/BRIEF.md
# NAND Bus Timing Sequencer

This block turns single-beat requests from a local master into the pin activity of an 8-bit asynchronous NAND device. Each request names an operation (write a byte, read a byte, or only update the latch-enable lines) and carries the command-latch and address-latch flags for that access. The block then drives chip enable, the write or read strobe, the two latch-enable lines and the data bus. It does this through four programmable phases, each counted in clock cycles: setup, strobe, hold and turnaround.

All phase lengths come from a single 32-bit timing word. Writes and reads have their own setup, strobe and hold fields. One turnaround field is shared by both. The word is sampled when a request is accepted, so it may change while an access is in progress. The device ready/busy line passes through a synchronizer and is reported as bit 0 of a status output.

Top module: `nand_bus_timer`

## Requirements
- R1: A write access (req_op_i = 1) holds chip enable low through a setup phase, a strobe phase and a hold phase. These phases last cfg_i[29:26]+1, cfg_i[25:20]+1 and cfg_i[19:17]+1 cycles. The write strobe is low only during the strobe phase. The first setup cycle follows the acceptance edge.
- R2: A read access (req_op_i = 2) uses the same three phases, with lengths cfg_i[16:13]+1, cfg_i[12:7]+1 and cfg_i[6:4]+1. The read strobe is low only during the strobe phase.
- R3: After the hold phase, the bus stays deselected for cfg_i[3:2]+1 turnaround cycles and then one idle cycle, so a request held high restarts chip enable cfg_i[3:2]+2 cycles after the acknowledge cycle. After a latch-only request the gap is 1 cycle.
- R4: The write and read strobes are never low together, and neither is low while chip enable is high.
- R5: The command-latch and address-latch outputs take the request's flags at acceptance and hold them, unchanged, until the next accepted request.
- R6: A latch-only request (req_op_i = 0 or 3) updates the command-latch and address-latch outputs and acknowledges in the cycle after acceptance. It leaves chip enable and both strobes inactive.
- R7: For a write, the data byte captured at acceptance is driven with the output enable high from setup through hold. The output enable is low at all other times.
- R8: For a read, the bus value in the last strobe cycle is captured and appears on rd_data_o from the first hold cycle.
- R9: ack_o is high for exactly one cycle: the last hold cycle of an access, or the single cycle of a latch-only request. Requests are accepted only while idle, and the timing word is sampled at acceptance.
- R10: cfg_i bits 31, 30, 1 and 0 have no effect on timing.
- R11: The ready input reaches status_o[0] two clock edges after it changes.
- R12: During reset, chip enable and both strobes are high, the latch-enable lines, output enable and ack_o are low, and status_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Packed phase timing word |
| req_i | input | 1 | Request valid |
| req_op_i | input | 2 | 0/3 latch-only, 1 write, 2 read |
| req_cle_i | input | 1 | Command-latch flag for this access |
| req_ale_i | input | 1 | Address-latch flag for this access |
| req_data_i | input | 8 | Write byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Last captured read byte |
| status_o | output | 1 | Bit 0: synchronized device ready |
| nand_ce_no | output | 1 | Chip enable, active low |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe_o | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rdy_i | input | 1 | Device ready/busy |

## Verification
The bench sweeps the setup, strobe, hold and turnaround values, including the field maxima, for both writes and reads. It compares every pin in every cycle against a phase schedule computed from the field values. The unused field of the other direction is always loaded with a different value, so a swapped field decode shows up as wrong phase lengths. Requests are chained back to back while the timing word changes at each acknowledge, which separates timing sampled at acceptance from live timing. A value on the bus that changes every cycle pins read capture to the last strobe cycle. Junk in the ignored bits and interleaved latch-only requests complete the patterns.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;
  localparam int CFG_W = 32;
  localparam int SU_W  = 4;
  localparam int ST_W  = 6;
  localparam int HD_W  = 3;
  localparam int TA_W  = 2;
  localparam int CNT_W = ST_W;

  // field LSBs inside the timing word
  localparam int WSU_LSB = 26;
  localparam int WST_LSB = 20;
  localparam int WHD_LSB = 17;
  localparam int RSU_LSB = 13;
  localparam int RST_LSB = 7;
  localparam int RHD_LSB = 4;
  localparam int TA_LSB  = 2;

  typedef struct packed {
    logic [SU_W-1:0] setup;
    logic [ST_W-1:0] strobe;
    logic [HD_W-1:0] hold;
  } phase_t;

  typedef struct packed {
    phase_t          wr;
    phase_t          rd;
    logic [TA_W-1:0] turn;
  } timing_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_TURN, ST_LATCH
  } state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_RSVD = 2'd3
  } op_e;
endpackage

// File: rtl/nand_cfg_unpack.sv
module nand_cfg_unpack
  import nand_tim_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output timing_t          tcfg_o
);
  always_comb begin
    tcfg_o.wr.setup  = cfg_i[WSU_LSB +: SU_W];
    tcfg_o.wr.strobe = cfg_i[WST_LSB +: ST_W];
    tcfg_o.wr.hold   = cfg_i[WHD_LSB +: HD_W];
    tcfg_o.rd.setup  = cfg_i[RSU_LSB +: SU_W];
    tcfg_o.rd.strobe = cfg_i[RST_LSB +: ST_W];
    tcfg_o.rd.hold   = cfg_i[RHD_LSB +: HD_W];
    tcfg_o.turn      = cfg_i[TA_LSB +: TA_W];
  end
endmodule

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else if (g == 0) chain_q[g] <= async_i;
      else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

  p_sync_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sync_o) |-> sync_o == $past(async_i, STAGES));
endmodule

// File: rtl/nand_phase_fsm.sv
module nand_phase_fsm
  import nand_tim_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    kind_rd_i,
  input  logic    kind_none_i,
  input  timing_t tcfg_i,
  output state_e  state_o,
  output logic    last_o
);
  state_e          state_q;
  phase_t          sel_q;
  logic [TA_W-1:0] turn_q;
  logic [CNT_W-1:0] cnt_q;
  phase_t          pick;

  assign pick   = kind_rd_i ? tcfg_i.rd : tcfg_i.wr;
  assign last_o = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= '0;
      turn_q  <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          if (kind_none_i) state_q <= ST_LATCH;
          else begin
            state_q <= ST_SETUP;
            sel_q   <= pick;
            turn_q  <= tcfg_i.turn;
            cnt_q   <= CNT_W'(pick.setup);
          end
        end
        ST_SETUP: if (last_o) begin
          state_q <= ST_STROBE;
          cnt_q   <= CNT_W'(sel_q.strobe);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_STROBE: if (last_o) begin
          state_q <= ST_HOLD;
          cnt_q   <= CNT_W'(sel_q.hold);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_HOLD: if (last_o) begin
          state_q <= ST_TURN;
          cnt_q   <= CNT_W'(turn_q);
        end else cnt_q <= cnt_q - CNT_W'(1);
        ST_TURN: if (last_o) state_q <= ST_IDLE;
                 else cnt_q <= cnt_q - CNT_W'(1);
        ST_LATCH: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;

  p_latch_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LATCH |=> state_q == ST_IDLE);
  p_turn_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TURN && last_o) |=> state_q == ST_IDLE);
  p_idle_wait_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  p_setup_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i && !kind_none_i) |=> state_q == ST_SETUP);
endmodule

// File: rtl/nand_bus_timer.sv
module nand_bus_timer
  import nand_tim_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SYNC_ST = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_i,
  input  logic              req_i,
  input  logic [1:0]        req_op_i,
  input  logic              req_cle_i,
  input  logic              req_ale_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [0:0]        status_o,
  output logic              nand_ce_no,
  output logic              nand_cle_o,
  output logic              nand_ale_o,
  output logic              nand_we_no,
  output logic              nand_re_no,
  output logic [DATA_W-1:0] nand_dq_o,
  output logic              nand_dq_oe_o,
  input  logic [DATA_W-1:0] nand_dq_i,
  input  logic              nand_rdy_i
);
  timing_t tcfg;
  state_e  state;
  logic    last, start, op_rd, op_none, rd_q, rdy_s;
  logic    cle_q, ale_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic    active, strobing;

  assign op_rd   = (op_e'(req_op_i) == OP_READ);
  assign op_none = (op_e'(req_op_i) == OP_NONE) || (op_e'(req_op_i) == OP_RSVD);
  assign start   = req_i && (state == ST_IDLE);

  nand_cfg_unpack i_unpack (.cfg_i(cfg_i), .tcfg_o(tcfg));

  nand_phase_fsm i_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .kind_rd_i(op_rd), .kind_none_i(op_none),
    .tcfg_i(tcfg), .state_o(state), .last_o(last)
  );

  nand_rdy_sync #(.STAGES(SYNC_ST)) i_rdy (
    .clk_i, .rst_ni, .async_i(nand_rdy_i), .sync_o(rdy_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
      rd_q   <= 1'b0;
      wdat_q <= '0;
    end else if (start) begin
      cle_q <= req_cle_i;
      ale_q <= req_ale_i;
      rd_q  <= op_rd;
      if (!op_none) wdat_q <= req_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdat_q <= '0;
    else if (state == ST_STROBE && last && rd_q) rdat_q <= nand_dq_i;
  end

  assign active   = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign strobing = (state == ST_STROBE);

  assign nand_ce_no   = !active;
  assign nand_we_no   = !(strobing && !rd_q);
  assign nand_re_no   = !(strobing && rd_q);
  assign nand_cle_o   = cle_q;
  assign nand_ale_o   = ale_q;
  assign nand_dq_o    = wdat_q;
  assign nand_dq_oe_o = active && !rd_q;
  assign ack_o        = (state == ST_HOLD && last) || (state == ST_LATCH);
  assign rd_data_o    = rdat_q;
  assign status_o     = rdy_s;

  p_strobe_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  p_strobe_in_ce_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> !nand_ce_no);
  p_ack_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  p_latch_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start |=> $stable({nand_cle_o, nand_ale_o}));
  p_oe_in_ce_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nand_dq_oe_o |-> !nand_ce_no);
  p_wdata_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nand_dq_oe_o && $past(nand_dq_oe_o)) |-> $stable(nand_dq_o));
endmodule

// File: tb/test_nand_bus_timer.sv
module test_nand_bus_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] cfg_i;
  logic        req_i, req_cle_i, req_ale_i;
  logic [1:0]  req_op_i;
  logic [7:0]  req_data_i, rd_data_o, nand_dq_o, nand_dq_i;
  logic        ack_o, nand_ce_no, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no;
  logic        nand_dq_oe_o, nand_rdy_i;
  logic [0:0]  status_o;

  int vecs = 0;
  int errs = 0;
  int exp_gap = 0;

  always #4 clk = ~clk;

  nand_bus_timer i_nand_bus_timer (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i, .req_i, .req_op_i, .req_cle_i,
    .req_ale_i, .req_data_i, .ack_o, .rd_data_o, .status_o, .nand_ce_no,
    .nand_cle_o, .nand_ale_o, .nand_we_no, .nand_re_no, .nand_dq_o,
    .nand_dq_oe_o, .nand_dq_i, .nand_rdy_i
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkcfg(int ws, int wst, int wh, int rs, int rst,
                                        int rh, int ta, bit junk);
    return {junk ? 2'b11 : 2'b00, 4'(ws), 6'(wst), 3'(wh), 4'(rs), 6'(rst),
            3'(rh), 2'(ta), junk ? 2'b10 : 2'b00};
  endfunction

  // called at a negedge; returns at the negedge of the ack cycle with req still high
  task automatic access(input int op, input bit c, input bit a, input logic [7:0] d,
                        input logic [31:0] cfg, input int s, input int w, input int h,
                        input int t, input logic [7:0] base, input string tag);
    int  gap = 0;
    int  nack;
    bit  none = (op == 0) || (op == 3);
    bit  rd = (op == 2);
    bit  in_st;
    logic [6:0] exp_v, act_v;
    cfg_i = cfg; req_i = 1'b1; req_op_i = 2'(op);
    req_cle_i = c; req_ale_i = a; req_data_i = d;
    forever begin
      @(negedge clk);
      if (none ? ack_o : !nand_ce_no) break;
      gap++;
      if (gap > 300) break;
    end
    chk({tag, " R3 R9 gap"}, 32'(gap), 32'(exp_gap));
    req_data_i = ~d;
    nack = none ? 1 : s + w + h + 3;
    for (int n = 1; n <= nack; n++) begin
      if (n > 1) @(negedge clk);
      in_st = !none && (n > s + 1) && (n <= s + w + 2);
      exp_v = {none, !(in_st && !rd), !(in_st && rd), n == nack, c, a, !none && !rd};
      act_v = {nand_ce_no, nand_we_no, nand_re_no, ack_o, nand_cle_o, nand_ale_o,
               nand_dq_oe_o};
      chk({tag, " R4 R5 R6 R7 R9 pins"}, 32'(act_v), 32'(exp_v));
      if (!none && !rd) chk({tag, " R7 wdata"}, 32'(nand_dq_o), 32'(d));
      nand_dq_i = base ^ 8'(n);
    end
    if (rd) chk({tag, " R8 rdata"}, 32'(rd_data_o), 32'(base ^ 8'(s + w + 2)));
    exp_gap = none ? 1 : t + 2;
  endtask

  initial begin
    int sv[4] = '{0, 1, 2, 15};
    int wv[3] = '{0, 1, 63};
    int hv[3] = '{0, 2, 7};
    int k = 0;
    rst_n = 1'b0; req_i = 1'b0; req_op_i = 2'd0; req_cle_i = 1'b0; req_ale_i = 1'b0;
    req_data_i = 8'h00; cfg_i = 32'h0; nand_dq_i = 8'h00; nand_rdy_i = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R12 reset pins",
        32'({nand_ce_no, nand_we_no, nand_re_no, nand_cle_o, nand_ale_o, nand_dq_oe_o,
             ack_o, status_o}), 32'(8'b1110_0000));
    rst_n = 1'b1;
    @(negedge clk);
    for (int si = 0; si < 4; si++)
      for (int wi = 0; wi < 3; wi++)
        for (int hi = 0; hi < 3; hi++)
          for (int t = 0; t < 4; t += (t == 1) ? 2 : 1)
            for (int rdk = 0; rdk < 2; rdk++) begin
              int s = sv[si], w = wv[wi], h = hv[hi];
              bit junk = k[0];
              logic [31:0] cfg;
              string tag;
              if (rdk == 1) begin
                cfg = mkcfg((s + 3) % 16, (w + 7) % 64, (h + 1) % 8, s, w, h, t, junk);
                tag = junk ? "R2 R10" : "R2";
                access(2, 1'b0, 1'b0, 8'h00, cfg, s, w, h, t, 8'(k * 37), tag);
              end else begin
                cfg = mkcfg(s, w, h, (s + 5) % 16, (w + 9) % 64, (h + 2) % 8, t, junk);
                tag = junk ? "R1 R10" : "R1";
                access(1, (k % 3) == 0, (k % 3) == 1, 8'(k * 13 + 5), cfg, s, w, h, t,
                       8'h00, tag);
              end
              if ((k % 5) == 4)
                access((k % 10 == 4) ? 0 : 3, k[1], !k[1], 8'hA5, cfg, 0, 0, 0, 0,
                       8'h00, "R6");
              k++;
            end
    req_i = 1'b0;
    repeat (8) @(negedge clk);
    exp_gap = 0;
    access(1, 1'b1, 1'b0, 8'h70, mkcfg(1, 3, 1, 1, 5, 1, 3, 1'b0), 1, 3, 1, 3,
           8'h00, "R1 R9 idle");
    req_i = 1'b0;
    repeat (8) @(negedge clk);
    nand_rdy_i = 1'b1;
    @(negedge clk); chk("R11 rdy one edge", 32'(status_o), 32'd0);
    @(negedge clk); chk("R11 rdy two edges", 32'(status_o), 32'd1);
    nand_rdy_i = 1'b0;
    @(negedge clk); chk("R11 busy one edge", 32'(status_o), 32'd1);
    @(negedge clk); chk("R11 busy two edges", 32'(status_o), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule